// File: doc/BRIEF.md
# Frame-Synchronized Video Configuration Registers

This block is the software-facing register file of a video processing core. A processor reaches it over a plain 32-bit read/write bus with a byte offset. Software sets a core enable, a bypass switch, a test-pattern switch and the frame dimensions. It also sets a flag that allows staged values to be applied. The core reads these settings from dedicated output pins.

Writes for bypass, test pattern and frame size go into a staging copy. The staging copy moves into the active copy only at a frame boundary. A frame boundary is the rising edge of the vertical blanking input, and the move happens only while both the enable flag and the apply flag are set. This keeps a frame from using a mix of old and new settings.

Two reset controls sit in the control word:
- An immediate reset clears all configuration and holds the core in reset until software releases it.
- An armed reset waits for the next frame boundary. At that boundary it clears everything, pulses the core reset for one cycle and disarms itself.

Top module: `vidcfg_regs`

## Requirements
- R1: After the synchronous reset input, every configuration output and `core_rst` are 0, and every readable offset returns 0 except the version word.
- R2: The control word at offset 0x000 holds core enable in bit 0, apply-enable in bit 1, bypass in bit 4, test pattern in bit 5, armed reset in bit 30 and immediate reset in bit 31. Reads return exactly these bits, with all others 0. `core_en` follows bit 0 from the clock edge that takes the write.
- R3: Writes to bypass, test pattern and the frame size word at 0x020 (height in bits 31:16, width in bits 15:0) are readable at once. They do not change `bypass_en`, `tpat_en`, `frame_width` or `frame_height` before a commit.
- R4: A commit copies the staged values to the outputs. It happens when a rising edge of `vblank_in` is seen while enable and apply-enable are both 1. `vblank_in` is sampled at clock edge k, and the outputs change at edge k+1.
- R5: No commit happens while apply-enable is 0 or enable is 0. While `vblank_in` stays high, there is no further commit.
- R6: A control write with bit 31 set has these effects from that write's edge onward:
  - All staged and active configuration and the IRQ-enable word are cleared.
  - `core_rst` is held at 1.
  - Writes to the other registers are ignored.
  - This lasts until a control write with bit 31 clear.
- R7: A control write with bit 30 set arms a reset, and reads show bit 30 as 1. At the next frame boundary (the same edge a commit would use), all configuration, the IRQ-enable word and bit 30 clear. `core_rst` is then 1 for exactly one cycle.
- R8: Offset 0x010 always reads 0x0001_0200, and writes to it are ignored.
- R9: Reads of unmapped offsets, of offset 0x008 and of offset 0x024 return 0. `bus_rdata` is 0 whenever `bus_rd` is low.
- R10: The status word at 0x004 is read-only. It returns `core_en` in bit 0, the active bypass in bit 4 and the active test pattern in bit 5.
- R11: The IRQ-enable word at 0x00C stores and returns all 32 bits written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, qualifies `bus_rdata` |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the offset |
| vblank_in | input | 1 | Vertical blanking level from the timing source |
| core_rst | output | 1 | Reset to the processing core |
| core_en | output | 1 | Core enable |
| bypass_en | output | 1 | Active bypass setting |
| tpat_en | output | 1 | Active test-pattern setting |
| frame_width | output | 16 | Active line width |
| frame_height | output | 16 | Active frame height |

## Verification
Read data is combinational, so the bench samples it in the same cycle it drives the strobe. A register write is visible on reads and on `core_en` one edge after it is driven. A commit or an armed reset lands two edges after `vblank_in` rises, because one edge captures the level and the next acts on the detected edge. The bench therefore raises `vblank_in` at a falling edge and checks the outputs two falling edges later. For the armed-reset pulse, it checks once more one cycle after that to confirm the pulse lasted exactly one cycle. Checks that confirm nothing changed wait several cycles before they look.

// File: rtl/vidcfg_pkg.sv
package vidcfg_pkg;

    localparam int BUS_W    = 32;
    localparam int OFS_W    = 12;
    localparam int DIM_W    = BUS_W / 2;

    localparam logic [OFS_W-1:0] OFS_CTRL    = 12'h000;
    localparam logic [OFS_W-1:0] OFS_STATUS  = 12'h004;
    localparam logic [OFS_W-1:0] OFS_IRQEN   = 12'h00C;
    localparam logic [OFS_W-1:0] OFS_VERSION = 12'h010;
    localparam logic [OFS_W-1:0] OFS_SIZE    = 12'h020;

    localparam int B_EN   = 0;
    localparam int B_UPD  = 1;
    localparam int B_BYP  = 4;
    localparam int B_TPAT = 5;
    localparam int B_ARM  = 30;
    localparam int B_IMM  = 31;

    localparam logic [BUS_W-1:0] VERSION_WORD = 32'h0001_0200;

    typedef struct packed {
        logic imm;
        logic arm;
        logic tpat;
        logic byp;
        logic upd;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic             tpat;
        logic             byp;
        logic [DIM_W-1:0] height;
        logic [DIM_W-1:0] width;
    } frame_cfg_t;

    function automatic logic [BUS_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [BUS_W-1:0] w;
        w         = '0;
        w[B_EN]   = c.en;
        w[B_UPD]  = c.upd;
        w[B_BYP]  = c.byp;
        w[B_TPAT] = c.tpat;
        w[B_ARM]  = c.arm;
        w[B_IMM]  = c.imm;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(input logic [BUS_W-1:0] w);
        ctrl_t c;
        c.en   = w[B_EN];
        c.upd  = w[B_UPD];
        c.byp  = w[B_BYP];
        c.tpat = w[B_TPAT];
        c.arm  = w[B_ARM];
        c.imm  = w[B_IMM];
        return c;
    endfunction

endpackage

// File: rtl/vidcfg_edge.sv
module vidcfg_edge (
    input  logic clk,
    input  logic rst,
    input  logic level_in,
    output logic rise_pulse
);
    logic cur_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            cur_q  <= level_in;
            prev_q <= cur_q;
        end
    end

    assign rise_pulse = cur_q & ~prev_q;
endmodule

// File: rtl/vidcfg_stage.sv
module vidcfg_stage
    import vidcfg_pkg::*;
#(
    parameter int ADDR_W = OFS_W,
    parameter int DATA_W = BUS_W,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sync_fire,
    output ctrl_t             ctrl,
    output logic [HALF_W-1:0] st_height,
    output logic [HALF_W-1:0] st_width,
    output logic [DATA_W-1:0] irq_en,
    output logic              imm_req
);
    logic wr_ctrl;
    logic wr_size;
    logic wr_irq;

    assign wr_ctrl = wr && (addr == ADDR_W'(OFS_CTRL));
    assign wr_size = wr && (addr == ADDR_W'(OFS_SIZE));
    assign wr_irq  = wr && (addr == ADDR_W'(OFS_IRQEN));
    assign imm_req = wr_ctrl && wdata[B_IMM];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            st_height <= '0;
            st_width  <= '0;
            irq_en    <= '0;
        end else if (imm_req) begin
            ctrl      <= '0;
            ctrl.imm  <= 1'b1;
            st_height <= '0;
            st_width  <= '0;
            irq_en    <= '0;
        end else if (sync_fire) begin
            ctrl      <= '0;
            st_height <= '0;
            st_width  <= '0;
            irq_en    <= '0;
        end else if (wr_ctrl) begin
            ctrl <= word_to_ctrl(BUS_W'(wdata));
        end else if (!ctrl.imm) begin
            if (wr_size) begin
                st_height <= wdata[DATA_W-1:HALF_W];
                st_width  <= wdata[HALF_W-1:0];
            end
            if (wr_irq) begin
                irq_en <= wdata;
            end
        end
    end
endmodule

// File: rtl/vidcfg_commit.sv
module vidcfg_commit
    import vidcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_edge,
    input  logic       sync_fire,
    input  logic       imm_req,
    input  ctrl_t      ctrl,
    input  frame_cfg_t staged,
    output frame_cfg_t active,
    output logic       sync_pulse
);
    logic do_clear;
    logic do_commit;

    assign do_clear  = imm_req || ctrl.imm || sync_fire;
    assign do_commit = frame_edge && ctrl.en && ctrl.upd;

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= '0;
            sync_pulse <= 1'b0;
        end else begin
            sync_pulse <= sync_fire;
            if (do_clear) begin
                active <= '0;
            end else if (do_commit) begin
                active <= staged;
            end
        end
    end
endmodule

// File: rtl/vidcfg_regs.sv
module vidcfg_regs
    import vidcfg_pkg::*;
#(
    parameter int              ADDR_W  = OFS_W,
    parameter int              DATA_W  = BUS_W,
    parameter logic [BUS_W-1:0] VERSION = VERSION_WORD,
    localparam int             HALF_W  = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              vblank_in,
    output logic              core_rst,
    output logic              core_en,
    output logic              bypass_en,
    output logic              tpat_en,
    output logic [HALF_W-1:0] frame_width,
    output logic [HALF_W-1:0] frame_height
);
    ctrl_t             ctrl;
    frame_cfg_t        staged;
    frame_cfg_t        active;
    logic [HALF_W-1:0] st_height;
    logic [HALF_W-1:0] st_width;
    logic [DATA_W-1:0] irq_en;
    logic              imm_req;
    logic              edge_pulse;
    logic              sync_fire;
    logic              sync_pulse;

    vidcfg_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .level_in  (vblank_in),
        .rise_pulse(edge_pulse)
    );

    assign sync_fire = ctrl.arm && edge_pulse;

    vidcfg_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .sync_fire(sync_fire),
        .ctrl     (ctrl),
        .st_height(st_height),
        .st_width (st_width),
        .irq_en   (irq_en),
        .imm_req  (imm_req)
    );

    assign staged.tpat   = ctrl.tpat;
    assign staged.byp    = ctrl.byp;
    assign staged.height = DIM_W'(st_height);
    assign staged.width  = DIM_W'(st_width);

    vidcfg_commit u_commit (
        .clk       (clk),
        .rst       (rst),
        .frame_edge(edge_pulse),
        .sync_fire (sync_fire),
        .imm_req   (imm_req),
        .ctrl      (ctrl),
        .staged    (staged),
        .active    (active),
        .sync_pulse(sync_pulse)
    );

    assign core_rst     = ctrl.imm | sync_pulse;
    assign core_en      = ctrl.en;
    assign bypass_en    = active.byp;
    assign tpat_en      = active.tpat;
    assign frame_width  = HALF_W'(active.width);
    assign frame_height = HALF_W'(active.height);

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                ADDR_W'(OFS_CTRL): bus_rdata = DATA_W'(ctrl_to_word(ctrl));
                ADDR_W'(OFS_STATUS): begin
                    bus_rdata[B_EN]   = core_en;
                    bus_rdata[B_BYP]  = active.byp;
                    bus_rdata[B_TPAT] = active.tpat;
                end
                ADDR_W'(OFS_IRQEN):   bus_rdata = irq_en;
                ADDR_W'(OFS_VERSION): bus_rdata = DATA_W'(VERSION);
                ADDR_W'(OFS_SIZE):    bus_rdata = {st_height, st_width};
                default:              bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/vidcfg_regs_chk.sv
module vidcfg_regs_chk #(
    parameter int DATA_W = 32,
    parameter int HALF_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              core_rst,
    input logic              core_en,
    input logic              bypass_en,
    input logic              tpat_en,
    input logic [HALF_W-1:0] frame_width,
    input logic              edge_pulse
);
    AST_WIDTH_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
        !$stable(frame_width) |-> (core_rst || $past(edge_pulse))); // R4

    AST_NO_COMMIT_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!$stable(bypass_en) && !core_rst) |-> $past(core_en)); // R5

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        core_rst |-> (!core_en && !bypass_en && !tpat_en && frame_width == '0)); // R6

    AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ($rose(core_rst) && !$past(bus_wr) && !bus_wr) |=> !core_rst); // R7

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0)); // R9
endmodule

bind vidcfg_regs vidcfg_regs_chk #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_rdata   (bus_rdata),
    .core_rst    (core_rst),
    .core_en     (core_en),
    .bypass_en   (bypass_en),
    .tpat_en     (tpat_en),
    .frame_width (frame_width),
    .edge_pulse  (edge_pulse)
);

// File: tb/vidcfg_regs_test.sv
`timescale 1ns/1ps
module vidcfg_regs_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        vblank_in = 1'b0;
    logic        core_rst, core_en, bypass_en, tpat_en;
    logic [15:0] frame_width, frame_height;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [31:0] VER = 32'h0001_0200;

    always #2 clk = ~clk;

    vidcfg_regs uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .vblank_in(vblank_in), .core_rst(core_rst), .core_en(core_en),
        .bypass_en(bypass_en), .tpat_en(tpat_en),
        .frame_width(frame_width), .frame_height(frame_height)
    );

    // {offset, write data, expected read back}
    localparam int NV = 9;
    localparam logic [75:0] VEC [NV] = '{
        {12'h000, 32'h0000_0033, 32'h0000_0033},  // R2
        {12'h000, 32'h0000_FFFF, 32'h0000_0033},  // R2
        {12'h020, 32'h0438_0780, 32'h0438_0780},  // R3
        {12'h00C, 32'hA5A5_0003, 32'hA5A5_0003},  // R11
        {12'h010, 32'hDEAD_BEEF, VER},            // R8
        {12'h008, 32'hFFFF_FFFF, 32'h0000_0000},  // R9
        {12'h024, 32'h0000_1234, 32'h0000_0000},  // R9
        {12'h100, 32'h0000_0001, 32'h0000_0000},  // R9
        {12'h004, 32'h0000_00FF, 32'h0000_0001}   // R10
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic vb_rise();
        @(negedge clk);
        vblank_in = 1'b1;
        idle(2);
    endtask

    task automatic vb_fall();
        @(negedge clk);
        vblank_in = 1'b0;
        idle(2);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        check("R1 outputs", {core_rst, core_en, bypass_en, tpat_en, frame_width, frame_height}, 32'h0);
        rd(12'h000, r); check("R1 ctrl", r, 32'h0);
        rd(12'h020, r); check("R1 size", r, 32'h0);
        rd(12'h010, r); check("R1 version", r, VER);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][75:64], VEC[i][63:32]);
            rd(VEC[i][75:64], r);
            check("R2/R3/R8/R9/R10/R11 table", r, VEC[i][31:0]);
        end
        check("R2 core_en", {31'b0, core_en}, 32'h1);

        // R3 staged only
        idle(4);
        check("R3 no commit", {14'b0, bypass_en, tpat_en, frame_width}, 32'h0);

        // R4 commit at frame edge
        vb_rise();
        check("R4 flags", {30'b0, bypass_en, tpat_en}, 32'h3);
        check("R4 size", {frame_height, frame_width}, 32'h0438_0780);
        rd(12'h004, r); check("R10 status", r, 32'h31);
        vb_fall();

        // R5 apply-enable clear
        wr(12'h000, 32'h0000_0011);
        wr(12'h020, 32'h0010_0020);
        vb_rise();
        check("R5 upd clear", {14'b0, bypass_en, tpat_en, frame_width}, 32'h3_0780);
        vb_fall();
        // R5 enable clear
        wr(12'h000, 32'h0000_0002);
        vb_rise();
        check("R5 en clear", {13'b0, core_en, bypass_en, tpat_en, frame_width}, 32'h3_0780);
        vb_fall();
        // R5 level held: one commit only
        wr(12'h000, 32'h0000_0003);
        vb_rise();
        check("R4 second commit", {14'b0, bypass_en, tpat_en, frame_width}, 32'h0_0020);
        wr(12'h020, 32'h0005_0006);
        idle(4);
        check("R5 held vblank", {frame_height, frame_width}, 32'h0010_0020);
        vb_fall();

        // R6 immediate reset
        wr(12'h000, 32'h8000_0000);
        check("R6 core_rst", {31'b0, core_rst}, 32'h1);
        check("R6 cleared", {13'b0, core_en, bypass_en, tpat_en, frame_width}, 32'h0);
        rd(12'h000, r); check("R6 ctrl", r, 32'h8000_0000);
        wr(12'h020, 32'h0007_0008);
        rd(12'h020, r); check("R6 write ignored", r, 32'h0);
        idle(5);
        check("R6 held", {31'b0, core_rst}, 32'h1);
        wr(12'h000, 32'h0000_0000);
        check("R6 release", {31'b0, core_rst}, 32'h0);

        // R7 armed reset
        wr(12'h020, 32'h1111_2222);
        wr(12'h00C, 32'h0000_0007);
        wr(12'h000, 32'h4000_0000);
        rd(12'h000, r); check("R7 armed", r, 32'h4000_0000);
        idle(3);
        check("R7 wait", {31'b0, core_rst}, 32'h0);
        @(negedge clk);
        vblank_in = 1'b1;
        idle(2);
        check("R7 pulse", {31'b0, core_rst}, 32'h1);
        idle(1);
        check("R7 pulse end", {31'b0, core_rst}, 32'h0);
        rd(12'h000, r); check("R7 ctrl clear", r, 32'h0);
        rd(12'h020, r); check("R7 size clear", r, 32'h0);
        rd(12'h00C, r); check("R7 irq clear", r, 32'h0);
        vb_fall();

        // R9 idle read
        @(negedge clk);
        bus_addr = 12'h010;
        #1 check("R9 rd low", bus_rdata, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule